// File: doc/BRIEF.md
# Burst-of-Four Split-Port Pipelined SRAM

This block is a synthesizable behavioural memory with one port that only reads and one that only writes. The two ports run at the same time. A command on either port names a burst address. The block then moves four consecutive words, and it forms the two low word-address bits itself in the order 0, 1, 2, 3. In the external device the data moves on both edges of the main clock. Here each of those edges is one cycle of a fast clock `clk_i`, and a phase flag tells them apart. Phase 0 marks the main-clock rising edge (the "K edge"), and phase 1 marks the complementary edge. Commands are sampled only on K edges.

A write command carries no data. Its four data beats, each with an active-low mask per byte lane, follow one main-clock cycle later on four consecutive fast edges. Read data leaves on four consecutive fast cycles with the same one-main-cycle latency, and a valid flag stands in for the output enable. A read issued on the same K edge and to the same burst address as a write returns the new data of each beat, merged lane by lane with the old contents.

Top module: `ssram_b4_split`

## Requirements
- R1: While `rst_ni` is low, `rd_valid_o` is 0, `rd_data_o` is all zeros and `k_phase_o` is 0. The first `clk_i` edge after release is a K edge.
- R2: `k_phase_o` toggles on every `clk_i` edge. It is 0 in the cycle before a K edge. A select that is low at a non-K edge (`k_phase_o` = 1) is ignored.
- R3: A read accepted at K edge E with burst address A sets `rd_valid_o` to 1 after edges E+2, E+3, E+4 and E+5. In those four cycles `rd_data_o` shows the words {A,2'b00}, {A,2'b01}, {A,2'b10} and {A,2'b11}, in that order.
- R4: A write accepted at K edge E with burst address A stores the `wr_data_i` values sampled at edges E+2, E+3, E+4 and E+5 into words {A,0}, {A,1}, {A,2} and {A,3}.
- R5: `wr_lane_ni` is sampled with each write beat. Bit 0 covers data bits 8:0 and bit 1 covers data bits 17:9. A lane is written when its bit is 0. A lane whose bit is 1 keeps its old contents.
- R6: A port accepts a command only at a K edge. It accepts it when the port is idle or in the last K cycle of its current burst. A select at the K edge E+2 of a burst accepted at E is ignored. A command at E+4 follows with no gap between the bursts.
- R7: A write beat is stored whether or not `wr_sel_ni` is still low. `wr_data_i` and `wr_lane_ni` have no effect on the array at edges that carry no beat.
- R8: A read and a write can both be accepted at the same K edge, and they proceed independently.
- R9: A read accepted at the same K edge as a write to the same burst address returns, for each beat, the write beat merged with the old contents according to R5.
- R10: In every cycle where `rd_valid_o` is 0, `rd_data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, one edge per data beat |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_ni | input | 1 | Read port select, active low, sampled at K edges |
| rd_addr_i | input | ADDR_W | Read burst address |
| wr_sel_ni | input | 1 | Write port select, active low, sampled at K edges |
| wr_addr_i | input | ADDR_W | Write burst address |
| wr_data_i | input | DATA_W | Write data beat |
| wr_lane_ni | input | LANES | Per-lane write mask, active low, one bit per lane |
| rd_data_o | output | DATA_W | Read data beat, zero while not valid |
| rd_valid_o | output | 1 | Read data valid (output enable) |
| k_phase_o | output | 1 | 0 when the next edge is a K edge |

## Verification
The bench counts edges from reset release, so edge n is a K edge exactly when n is even. A command accepted at edge E has its write beats sampled at edges E+2 through E+5 and its read beats registered at those same edges. After each edge the bench samples the outputs on the following falling edge. It compares them with the value its reference memory held just before that edge, merged with any write beat that lands on the same word at the same edge, which covers the forwarding case. Select pulses at odd edges and at E+2 are driven on purpose, and their effect is seen one burst later through the read data and the valid flag.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W = $clog2(BURST_LEN);
  typedef logic [BEAT_W-1:0] beat_t;
  localparam beat_t LAST_BEAT = beat_t'(BURST_LEN - 1);
  localparam beat_t MID_BEAT  = beat_t'(BURST_LEN - 2);
endpackage

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int AW     = 10,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH  = 2 ** AW;
  localparam int LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lane_en_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/ssram_port_seq.sv
module ssram_port_seq
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              k_edge_i,
  input  logic              sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pend_o,
  output logic              act_o,
  output logic [ADDR_W-1:0] addr_o,
  output beat_t             beat_o
);
  logic              pend_q, act_q;
  logic [ADDR_W-1:0] pend_addr_q, addr_q;
  beat_t             beat_q;
  logic              accept;

  // new burst may overlap only the final main-clock cycle of the previous one
  assign accept = k_edge_i && !sel_ni && (!act_q || beat_q == MID_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      act_q       <= 1'b0;
      addr_q      <= '0;
      beat_q      <= '0;
    end else begin
      pend_q <= accept;
      if (accept) pend_addr_q <= addr_i;
      if (pend_q) begin
        act_q  <= 1'b1;
        addr_q <= pend_addr_q;
        beat_q <= '0;
      end else if (act_q) begin
        if (beat_q == LAST_BEAT) act_q <= 1'b0;
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign addr_o = addr_q;
  assign beat_o = beat_q;
endmodule

// File: rtl/ssram_b4_split.sv
module ssram_b4_split
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_sel_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_sel_ni,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  wr_lane_ni,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              k_phase_o
);
  localparam int WORD_AW = ADDR_W + BEAT_W;
  localparam int LANE_W  = DATA_W / LANES;

  logic              phase_q;
  logic              rd_pend, rd_act, wr_pend, wr_act;
  logic [ADDR_W-1:0] rd_base, wr_base;
  beat_t             rd_beat, wr_beat;
  logic [WORD_AW-1:0] rd_word, wr_word;
  logic [DATA_W-1:0] arr_q, fwd_d, rdata_q;
  logic              fwd_hit, rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= !phase_q;
  end

  ssram_port_seq #(.ADDR_W(ADDR_W)) u_rd_seq (
    .clk_i, .rst_ni, .k_edge_i(!phase_q), .sel_ni(rd_sel_ni), .addr_i(rd_addr_i),
    .pend_o(rd_pend), .act_o(rd_act), .addr_o(rd_base), .beat_o(rd_beat)
  );

  ssram_port_seq #(.ADDR_W(ADDR_W)) u_wr_seq (
    .clk_i, .rst_ni, .k_edge_i(!phase_q), .sel_ni(wr_sel_ni), .addr_i(wr_addr_i),
    .pend_o(wr_pend), .act_o(wr_act), .addr_o(wr_base), .beat_o(wr_beat)
  );

  assign rd_word = {rd_base, rd_beat};
  assign wr_word = {wr_base, wr_beat};

  ssram_array #(.AW(WORD_AW), .DATA_W(DATA_W), .LANES(LANES)) u_array (
    .clk_i,
    .we_i     (wr_act),
    .waddr_i  (wr_word),
    .wdata_i  (wr_data_i),
    .lane_en_i(~wr_lane_ni),
    .raddr_i  (rd_word),
    .rdata_o  (arr_q)
  );

  // beat landing this edge is not yet in the array
  assign fwd_hit = wr_act && rd_act && (wr_word == rd_word);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign fwd_d[g*LANE_W +: LANE_W] = (fwd_hit && !wr_lane_ni[g]) ?
        wr_data_i[g*LANE_W +: LANE_W] : arr_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_act;
      rdata_q  <= rd_act ? fwd_d : '0;
    end
  end

  assign rd_data_o  = rdata_q;
  assign rd_valid_o = rvalid_q;
  assign k_phase_o  = phase_q;
endmodule

// File: rtl/ssram_b4_split_chk.sv
module ssram_b4_split_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              k_phase_i,
  input logic              rd_valid_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              rd_pend_i,
  input logic              wr_pend_i
);
  logic [1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (rd_valid_i) run_q <= run_q + 2'd1;
    else                 run_q <= '0;
  end

  AST_PHASE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_phase_i |=> k_phase_i); // R2
  AST_PHASE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_phase_i |=> !k_phase_i); // R2
  AST_RD_ACCEPT_ON_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_i |-> k_phase_i); // R2
  AST_VALID_EDGE_ON_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_valid_i) || $fell(rd_valid_i)) |-> k_phase_i); // R3
  AST_VALID_WHOLE_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_valid_i) |-> run_q == 2'd0); // R3
  AST_WR_PEND_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend_i |=> !wr_pend_i); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |-> rd_data_i == '0); // R10
endmodule

bind ssram_b4_split ssram_b4_split_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .k_phase_i (k_phase_o),
  .rd_valid_i(rd_valid_o),
  .rd_data_i (rd_data_o),
  .rd_pend_i (rd_pend),
  .wr_pend_i (wr_pend)
);

// File: tb/ssram_b4_split_tb_top.sv
module ssram_b4_split_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 18;
  localparam int LANES = 2;
  localparam int WORDS = 2 ** (ADDR_W + 2);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_sel_ni = 1'b1, wr_sel_ni = 1'b1;
  logic [ADDR_W-1:0] rd_addr_i = '0, wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [LANES-1:0]  wr_lane_ni = '1;
  logic [DATA_W-1:0] rd_data_o;
  logic              rd_valid_o, k_phase_o;

  int checks = 0;
  int failures = 0;
  int n = 0;
  int w_last = -10, r_last = -10;

  logic [DATA_W-1:0] ref_mem [WORDS];
  bit                ws_v [8];
  int                ws_a [8];
  logic [DATA_W-1:0] ws_d [8];
  logic [1:0]        ws_m [8];
  bit                rs_v [8];
  int                rs_a [8];
  string             rs_tag [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ssram_b4_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) dut_i (
    .clk_i(clk), .rst_ni, .rd_sel_ni, .rd_addr_i, .wr_sel_ni, .wr_addr_i,
    .wr_data_i, .wr_lane_ni, .rd_data_o, .rd_valid_o, .k_phase_o
  );

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
      input logic [DATA_W-1:0] new_w, input logic [1:0] m_n);
    logic [DATA_W-1:0] r = old_w;
    if (!m_n[0]) r[8:0]  = new_w[8:0];
    if (!m_n[1]) r[17:9] = new_w[17:9];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s edge=%0d actual=%h expected=%h", tag, n, act, exp);
    end
  endtask

  // one clk_i edge: drive, model, wait, check
  task automatic step(input bit rs, input int ra, input bit ws, input int wa,
                      input logic [7:0] wm, input string tag);
    bit acc_r, acc_w, e_v;
    int idx;
    logic [DATA_W-1:0] e_d;
    string e_tag;
    acc_r = rs && (n % 2 == 0) && (r_last <= n + 1);
    acc_w = ws && (n % 2 == 0) && (w_last <= n + 1);
    rd_sel_ni = !rs;
    rd_addr_i = ADDR_W'(ra);
    wr_sel_ni = !ws;
    wr_addr_i = ADDR_W'(wa);
    if (acc_w) begin
      for (int k = 0; k < 4; k++) begin
        idx = (n + 2 + k) % 8;
        ws_v[idx] = 1'b1;
        ws_a[idx] = wa * 4 + k;
        ws_d[idx] = DATA_W'($urandom);
        ws_m[idx] = wm[2*k +: 2];
      end
      w_last = n + 5;
    end
    if (acc_r) begin
      for (int k = 0; k < 4; k++) begin
        idx = (n + 2 + k) % 8;
        rs_v[idx] = 1'b1;
        rs_a[idx] = ra * 4 + k;
        rs_tag[idx] = tag;
      end
      r_last = n + 5;
    end
    idx = n % 8;
    if (ws_v[idx]) begin
      wr_data_i  = ws_d[idx];
      wr_lane_ni = ws_m[idx];
    end else begin
      wr_data_i  = DATA_W'($urandom);   // R7: junk must not land
      wr_lane_ni = LANES'($urandom);
    end
    if (rs_v[idx]) begin
      e_d = ref_mem[rs_a[idx]];
      if (ws_v[idx] && ws_a[idx] == rs_a[idx]) e_d = merge(e_d, ws_d[idx], ws_m[idx]);
      e_v = 1'b1;
      e_tag = rs_tag[idx];
    end else begin
      e_d = '0;
      e_v = 1'b0;
      e_tag = tag;
    end
    if (ws_v[idx]) ref_mem[ws_a[idx]] = merge(ref_mem[ws_a[idx]], ws_d[idx], ws_m[idx]);
    ws_v[idx] = 1'b0;
    rs_v[idx] = 1'b0;
    @(negedge clk);
    check(e_tag, {13'd0, rd_valid_o, rd_data_o}, {13'd0, e_v, e_d});
    check("R2", {31'd0, k_phase_o}, {31'd0, (n % 2 == 0)});
    n++;
  endtask

  task automatic idle(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) step(1'b0, 0, 1'b0, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin ws_v[i] = 1'b0; rs_v[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1", {13'd0, rd_valid_o, rd_data_o}, 32'd0);
    check("R1", {31'd0, k_phase_o}, 32'd0);
    rst_ni = 1'b1;

    // fill addresses 0..15 with full-lane writes
    for (int a = 0; a < 16; a++) begin
      step(1'b0, 0, 1'b1, a, 8'h00, "R4");
      idle(3, "R10");
    end
    idle(4, "R10");
    step(1'b1, 3, 1'b0, 0, 8'h00, "R4"); idle(7, "R10");
    // R5: per-beat masks 01,10,11,00
    step(1'b0, 0, 1'b1, 3, 8'b00111001, "R5"); idle(7, "R10");
    step(1'b1, 3, 1'b0, 0, 8'h00, "R5"); idle(7, "R10");
    // R2: selects at a non-K edge are ignored
    idle(1, "R2");
    step(1'b1, 4, 1'b1, 4, 8'h00, "R2"); idle(6, "R2");
    step(1'b1, 4, 1'b0, 0, 8'h00, "R2"); idle(7, "R10");
    // R6: select at E+2 ignored, E+4 seamless
    step(1'b1, 5, 1'b0, 0, 8'h00, "R6"); idle(1, "R6");
    step(1'b1, 6, 1'b1, 6, 8'h00, "R6"); idle(1, "R6");
    step(1'b1, 7, 1'b0, 0, 8'h00, "R6"); idle(7, "R6");
    step(1'b0, 0, 1'b1, 8, 8'h00, "R6"); idle(3, "R6");
    step(1'b0, 0, 1'b1, 9, 8'h00, "R6"); idle(3, "R6");
    step(1'b1, 8, 1'b0, 0, 8'h00, "R6"); idle(3, "R6");
    step(1'b1, 9, 1'b0, 0, 8'h00, "R6"); idle(3, "R6");
    step(1'b1, 6, 1'b0, 0, 8'h00, "R6"); idle(7, "R10");
    // R7: write completes while select is high
    step(1'b0, 0, 1'b1, 10, 8'h00, "R7"); idle(7, "R7");
    step(1'b1, 10, 1'b0, 0, 8'h00, "R7"); idle(7, "R10");
    // R8: concurrent, different addresses
    step(1'b1, 11, 1'b1, 12, 8'h00, "R8"); idle(7, "R8");
    step(1'b1, 12, 1'b0, 0, 8'h00, "R8"); idle(7, "R10");
    // R9: concurrent, same address, mixed masks
    step(1'b1, 13, 1'b1, 13, 8'b01100100, "R9"); idle(7, "R9");
    step(1'b1, 13, 1'b1, 13, 8'h00, "R9"); idle(7, "R10");

    // random concurrent traffic on a small address range
    for (int i = 0; i < 600; i++) begin
      bit rs = ($urandom % 3) == 0;
      bit ws = ($urandom % 3) == 0;
      step(rs, int'($urandom % 16), ws, int'($urandom % 16), 8'($urandom),
           (rs || ws) ? "R3" : "R10");
    end
    idle(8, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule